// File: doc/BRIEF.md
# Channel Command Sequencer

This block holds the byte-wide command register of one serial communication channel. The host writes a command byte into it, and the block turns every command bit of that write into a single-cycle control pulse. The pulses go to the channel's receiver, transmitter, FIFO, status and DMA-status logic, and they leave one per cycle in a fixed order. Once the last pulse has gone out, the register clears itself to zero. A nonzero read value therefore tells the host that the previous command is still being carried out.

Bit 7 of the written byte selects one of two command sets. With bit 7 low, bits 6..0 are channel-control commands. With bit 7 high, the seven low bits are a payload that is handed to the timer logic in one pulse. A stall input models a low-priority arbiter: while it is high, no command step advances. A write that arrives while a command is still pending is dropped and raises a sticky error flag.

Top module: `chanCmdSeq`

## Requirements
- R1: After reset the register reads 0x00, `busy` and `wrErr` are low, and every strobe output is low.
- R2: A write taken while the register reads zero stores the byte. From the next cycle `rdData` returns the byte, and `busy` is high exactly when the byte is nonzero.
- R3: With bit 7 low and bit 4 low, the channel-control bits are bit 6 clear, bit 5 initialize, bit 1 enable receive, bit 0 disable receive, bit 3 enable transmit and bit 2 disable transmit. They are carried out in that order, one step per cycle, and bits that are not set take no cycle. The first step is output in the cycle after the write edge.
- R4: The clear step pulses `flushFifos`, `clrStatus`, `clrDma`, `rxDis` and `txDis` together in one cycle.
- R5: With bit 7 low and bit 4 (reset all) set, the only action is a single `rstAll` pulse, and every other bit of the byte is ignored.
- R6: The register reads its written value until the edge that ends the last step. From that edge on it reads zero and `busy` is low.
- R7: With bit 7 high, the block outputs a single `tmrCmd` pulse in the cycle after the write, with `tmrData` equal to bits 6..0. The register clears at the end of that cycle.
- R8: A write made while the register is nonzero leaves the register and the pending steps unchanged and sets `wrErr`. `wrErr` stays high until the next accepted write, which clears it.
- R9: While `stall` is high, no strobe is output and the register holds its value. Once `stall` falls, the steps resume where they stopped.
- R10: Writing 0x00 produces no strobe and leaves `busy` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Host write strobe |
| wrData | input | 8 | Host write byte |
| stall | input | 1 | Holds command processing while high |
| rdData | output | 8 | Register read value |
| busy | output | 1 | High while a command is pending |
| wrErr | output | 1 | Sticky flag for a write made while busy |
| flushFifos | output | 1 | Flush receive and transmit FIFOs |
| clrStatus | output | 1 | Clear current receive and transmit status |
| clrDma | output | 1 | Clear DMA status |
| initCh | output | 1 | Initialize channel |
| rxEn | output | 1 | Enable receiver |
| rxDis | output | 1 | Disable receiver |
| txEn | output | 1 | Enable transmitter |
| txDis | output | 1 | Disable transmitter |
| rstAll | output | 1 | Reset-all action |
| tmrCmd | output | 1 | Timer command pulse |
| tmrData | output | 7 | Timer payload, valid with `tmrCmd` |

## Verification
The strobes depend combinationally on the registered pending steps. For an accepted write with no stall, the step k places after the first one therefore appears in the k-th cycle after the cycle that follows the write edge, and the register reads zero one edge after the last step. The driver pushes one expected strobe vector per cycle into a queue, including empty vectors for stalled cycles, right after the write edge. The monitor pops one entry at every falling clock edge, so each pulse is compared in exactly the cycle it is due. The driver reads the register value and the error flag one time unit after the relevant rising edges: the edge that ended the last step, and the edge after a rejected write.

// File: rtl/chanCmdPkg.sv
package chanCmdPkg;

  localparam int CMD_W  = 8;
  localparam int PAY_W  = CMD_W - 1;
  localparam int N_STEP = 7;

  // mode 0 bit positions inside the written byte
  localparam int BIT_MODE   = 7;
  localparam int BIT_CLEAR  = 6;
  localparam int BIT_INIT   = 5;
  localparam int BIT_RSTALL = 4;
  localparam int BIT_TXEN   = 3;
  localparam int BIT_TXDIS  = 2;
  localparam int BIT_RXEN   = 1;
  localparam int BIT_RXDIS  = 0;

  // step slots, lowest index runs first
  localparam int STEP_CLEAR  = 0;
  localparam int STEP_INIT   = 1;
  localparam int STEP_RXEN   = 2;
  localparam int STEP_RXDIS  = 3;
  localparam int STEP_TXEN   = 4;
  localparam int STEP_TXDIS  = 5;
  localparam int STEP_RSTALL = 6;

  // control -> datapath
  typedef struct packed {
    logic [N_STEP-1:0] retire;
    logic              retireTmr;
    logic              finish;
  } seqCtl_t;

  // outgoing action strobes
  typedef struct packed {
    logic tmr;
    logic rstAll;
    logic txDis;
    logic txEn;
    logic rxDis;
    logic rxEn;
    logic init;
    logic clrDma;
    logic clrStat;
    logic flush;
  } strobe_t;

endpackage

// File: rtl/chanCmdPick.sv
module chanCmdPick #(
  parameter int N = 7
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         anyReq
);

  logic [N:0] seen;

  assign seen[0] = 1'b0;

  generate
    for (genvar i = 0; i < N; i++) begin : gSlot
      assign grant[i]  = req[i] & ~seen[i];
      assign seen[i+1] = seen[i] | req[i];
    end
  endgenerate

  assign anyReq = seen[N];

endmodule

// File: rtl/chanCmdData.sv
module chanCmdData
  import chanCmdPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [CMD_W-1:0]    wrData,
  input  logic                stall,
  input  seqCtl_t             ctl,
  output logic [CMD_W-1:0]    cmdReg,
  output logic [N_STEP-1:0]   pendMask,
  output logic                tmrPend,
  output logic                wrErr
);

  logic idle;
  logic accept;
  logic [N_STEP-1:0] newMask;

  function automatic logic [N_STEP-1:0] decodeCtl(input logic [PAY_W-1:0] b);
    logic [N_STEP-1:0] m;
    m = '0;
    if (b[BIT_RSTALL]) begin
      m[STEP_RSTALL] = 1'b1;
    end else begin
      m[STEP_CLEAR] = b[BIT_CLEAR];
      m[STEP_INIT]  = b[BIT_INIT];
      m[STEP_RXEN]  = b[BIT_RXEN];
      m[STEP_RXDIS] = b[BIT_RXDIS];
      m[STEP_TXEN]  = b[BIT_TXEN];
      m[STEP_TXDIS] = b[BIT_TXDIS];
    end
    return m;
  endfunction

  assign idle    = (cmdReg == '0);
  assign accept  = wrEn & idle;
  assign newMask = wrData[BIT_MODE] ? '0 : decodeCtl(wrData[PAY_W-1:0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg   <= '0;
      pendMask <= '0;
      tmrPend  <= 1'b0;
      wrErr    <= 1'b0;
    end else if (accept) begin
      cmdReg   <= wrData;
      pendMask <= newMask;
      tmrPend  <= wrData[BIT_MODE];
      wrErr    <= 1'b0;
    end else begin
      if (wrEn) wrErr <= 1'b1;
      pendMask <= pendMask & ~ctl.retire;
      if (ctl.retireTmr) tmrPend <= 1'b0;
      if (ctl.finish)    cmdReg  <= '0;
    end
  end

  AST_BUSY_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && cmdReg != '0 && !ctl.finish) |=> (cmdReg == $past(cmdReg))); // R8
  AST_BUSY_WRITE_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && cmdReg != '0) |=> wrErr); // R8
  AST_FINISH_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.finish |=> (cmdReg == '0)); // R6
  AST_BUSY_HAS_WORK: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReg != '0) |-> ((pendMask != '0) || tmrPend)); // R6
  AST_STALL_FREEZES: assert property (@(posedge clk) disable iff (!rstN)
    (stall && cmdReg != '0) |=> (pendMask == $past(pendMask) && cmdReg == $past(cmdReg))); // R9
  AST_ZERO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && cmdReg == '0 && wrData == '0) |=> (cmdReg == '0 && pendMask == '0 && !tmrPend)); // R10

endmodule

// File: rtl/chanCmdCtrl.sv
module chanCmdCtrl
  import chanCmdPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [N_STEP-1:0] pendMask,
  input  logic              tmrPend,
  input  logic              stall,
  output seqCtl_t           ctl,
  output strobe_t           strb
);

  logic [N_STEP-1:0] grant;
  logic              anyStep;
  logic              go;

  chanCmdPick #(.N(N_STEP)) uPick (
    .req    (pendMask),
    .grant  (grant),
    .anyReq (anyStep)
  );

  assign go = ~stall & (anyStep | tmrPend);

  always_comb begin
    ctl.retire    = go ? grant : '0;
    ctl.retireTmr = go & tmrPend;
    ctl.finish    = go & ((pendMask & ~grant) == '0);
  end

  always_comb begin
    strb         = '0;
    strb.tmr     = ctl.retireTmr;
    strb.flush   = ctl.retire[STEP_CLEAR];
    strb.clrStat = ctl.retire[STEP_CLEAR];
    strb.clrDma  = ctl.retire[STEP_CLEAR];
    strb.init    = ctl.retire[STEP_INIT];
    strb.rxEn    = ctl.retire[STEP_RXEN];
    strb.rxDis   = ctl.retire[STEP_CLEAR] | ctl.retire[STEP_RXDIS];
    strb.txEn    = ctl.retire[STEP_TXEN];
    strb.txDis   = ctl.retire[STEP_CLEAR] | ctl.retire[STEP_TXDIS];
    strb.rstAll  = ctl.retire[STEP_RSTALL];
  end

  AST_ONE_STEP_PER_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ctl.retire)); // R3
  AST_TMR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.retireTmr |-> (ctl.retire == '0)); // R7
  AST_RSTALL_ALONE: assert property (@(posedge clk) disable iff (!rstN)
    strb.rstAll |-> ($countones(strb) == 1)); // R5
  AST_RSTALL_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    strb.rstAll |=> !strb.rstAll); // R5

endmodule

// File: rtl/chanCmdSeq.sv
module chanCmdSeq
  import chanCmdPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [7:0]       wrData,
  input  logic             stall,
  output logic [7:0]       rdData,
  output logic             busy,
  output logic             wrErr,
  output logic             flushFifos,
  output logic             clrStatus,
  output logic             clrDma,
  output logic             initCh,
  output logic             rxEn,
  output logic             rxDis,
  output logic             txEn,
  output logic             txDis,
  output logic             rstAll,
  output logic             tmrCmd,
  output logic [6:0]       tmrData
);

  logic [CMD_W-1:0]  cmdReg;
  logic [N_STEP-1:0] pendMask;
  logic              tmrPend;
  seqCtl_t           ctl;
  strobe_t           strb;

  chanCmdData uData (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrData   (wrData),
    .stall    (stall),
    .ctl      (ctl),
    .cmdReg   (cmdReg),
    .pendMask (pendMask),
    .tmrPend  (tmrPend),
    .wrErr    (wrErr)
  );

  chanCmdCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .pendMask (pendMask),
    .tmrPend  (tmrPend),
    .stall    (stall),
    .ctl      (ctl),
    .strb     (strb)
  );

  assign rdData     = cmdReg;
  assign busy       = |cmdReg;
  assign flushFifos = strb.flush;
  assign clrStatus  = strb.clrStat;
  assign clrDma     = strb.clrDma;
  assign initCh     = strb.init;
  assign rxEn       = strb.rxEn;
  assign rxDis      = strb.rxDis;
  assign txEn       = strb.txEn;
  assign txDis      = strb.txDis;
  assign rstAll     = strb.rstAll;
  assign tmrCmd     = strb.tmr;
  assign tmrData    = strb.tmr ? cmdReg[PAY_W-1:0] : '0;

  AST_TMR_CLEARS_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    tmrCmd |=> !busy); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (strb == '0)); // R10

endmodule

// File: tb/chanCmdSeq_test.sv
module chanCmdSeq_test;

  localparam int B_FLUSH = 0, B_CLRST = 1, B_CLRDMA = 2, B_INIT = 3, B_RXEN = 4,
                 B_RXDIS = 5, B_TXEN = 6, B_TXDIS = 7, B_RSTALL = 8, B_TMR = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic stall = 1'b0;
  logic [7:0] rdData;
  logic busy, wrErr, flushFifos, clrStatus, clrDma, initCh, rxEn, rxDis, txEn, txDis, rstAll, tmrCmd;
  logic [6:0] tmrData;

  int checks = 0;
  int errors = 0;
  bit monEn = 1'b0;
  logic [16:0] expQ[$];
  string tagQ[$];

  chanCmdSeq uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .stall(stall),
    .rdData(rdData), .busy(busy), .wrErr(wrErr), .flushFifos(flushFifos),
    .clrStatus(clrStatus), .clrDma(clrDma), .initCh(initCh), .rxEn(rxEn),
    .rxDis(rxDis), .txEn(txEn), .txDis(txDis), .rstAll(rstAll),
    .tmrCmd(tmrCmd), .tmrData(tmrData)
  );

  always #5 clk = ~clk;

  function automatic logic [16:0] actual();
    return {(tmrCmd ? tmrData : 7'd0), tmrCmd, rstAll, txDis, txEn, rxDis, rxEn,
            initCh, clrDma, clrStatus, flushFifos};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int nSteps(input logic [7:0] d);
    if (d == 8'h00) return 0;
    if (d[7] || d[4]) return 1;
    return $countones(d[6:0]);
  endfunction

  function automatic void pushOne(input logic [16:0] v, input string tag);
    expQ.push_back(v);
    tagQ.push_back(tag);
  endfunction

  // expected per-cycle strobe vectors after the write edge
  function automatic void pushCmd(input logic [7:0] d, input int stallCyc, input string tag);
    logic [16:0] v;
    for (int i = 0; i < stallCyc; i++) pushOne(17'd0, "R9");
    if (d == 8'h00) return;
    if (d[7]) begin
      v = '0; v[B_TMR] = 1'b1; v[16:10] = d[6:0];
      pushOne(v, "R7");
      return;
    end
    if (d[4]) begin
      v = '0; v[B_RSTALL] = 1'b1;
      pushOne(v, "R5");
      return;
    end
    if (d[6]) begin
      v = '0; v[B_FLUSH] = 1; v[B_CLRST] = 1; v[B_CLRDMA] = 1; v[B_RXDIS] = 1; v[B_TXDIS] = 1;
      pushOne(v, "R4");
    end
    if (d[5]) begin v = '0; v[B_INIT]  = 1; pushOne(v, tag); end
    if (d[1]) begin v = '0; v[B_RXEN]  = 1; pushOne(v, tag); end
    if (d[0]) begin v = '0; v[B_RXDIS] = 1; pushOne(v, tag); end
    if (d[3]) begin v = '0; v[B_TXEN]  = 1; pushOne(v, tag); end
    if (d[2]) begin v = '0; v[B_TXDIS] = 1; pushOne(v, tag); end
  endfunction

  // monitor: one expected vector per cycle, idle cycles expect silence
  always @(negedge clk) begin
    if (monEn) begin
      logic [16:0] a;
      a = actual();
      if (expQ.size() > 0) begin
        logic [16:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(a == e, t, a, e);
      end else begin
        check(a == 17'd0, "R3", a, 0);
      end
    end
  end

  task automatic runCmd(input logic [7:0] d, input int stallCyc, input string tag);
    int n;
    n = nSteps(d);
    @(posedge clk); #1;
    wrEn = 1'b1; wrData = d; stall = (stallCyc > 0);
    @(posedge clk); #1;
    wrEn = 1'b0;
    pushCmd(d, stallCyc, tag);
    check(rdData == d, "R2", rdData, d);
    check(busy == (d != 8'h00), "R2", busy, (d != 8'h00));
    if (stallCyc > 0) begin
      repeat (stallCyc) @(posedge clk);
      #1;
      check(rdData == d, "R9", rdData, d);
      stall = 1'b0;
    end
    if (n > 0) begin
      repeat (n - 1) @(posedge clk);
      #1;
      check(rdData == d, "R6", rdData, d);
      @(posedge clk); #1;
      check(rdData == 8'h00, "R6", rdData, 0);
      check(!busy, "R6", busy, 0);
    end else begin
      check(!busy, "R10", busy, 0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(rdData == 8'h00, "R1", rdData, 0);
    check(!busy && !wrErr, "R1", {busy, wrErr}, 0);
    check(actual() == 17'd0, "R1", actual(), 0);
    rstN = 1'b1;
    monEn = 1'b1;

    runCmd(8'h6F, 0, "R3");   // all six channel-control steps in order
    runCmd(8'h0A, 0, "R3");   // enable transmit and receive only
    runCmd(8'h7F, 0, "R5");   // reset-all swallows the rest
    runCmd(8'h10, 0, "R5");
    runCmd(8'hD5, 0, "R7");   // timer payload 0x55
    runCmd(8'h05, 2, "R9");   // two stalled cycles before the steps
    runCmd(8'h00, 0, "R10");

    // R8: write during a pending command
    @(posedge clk); #1;
    wrEn = 1'b1; wrData = 8'h41;
    @(posedge clk); #1;
    pushCmd(8'h41, 0, "R8");
    wrData = 8'h02;
    @(posedge clk); #1;
    wrEn = 1'b0;
    check(wrErr, "R8", wrErr, 1);
    check(rdData == 8'h41, "R8", rdData, 8'h41);
    @(posedge clk); #1;
    check(rdData == 8'h00, "R8", rdData, 0);
    check(wrErr, "R8", wrErr, 1);
    runCmd(8'h02, 0, "R8");
    check(!wrErr, "R8", wrErr, 0);

    runCmd(8'h80, 0, "R7");   // timer payload zero
    repeat (3) @(posedge clk);
    #1;
    check(expQ.size() == 0, "R3", expQ.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule